// File: doc/BRIEF.md
# Interrupt Eligibility Mask Generator

This block holds the per-line state for a bank of interrupt lines, 32 by default. For every line it keeps a pending latch, a trigger-mode bit (edge or level), the sampled input level, an enable bit, an active bit, a group bit and a group-modifier bit. From that state, three global group enables and one security-disable control, it produces a registered vector. Each set bit in the vector marks a line that may be offered to a CPU interface. Priority selection, routing and bus decoding are left to the blocks around it.

Software-side state changes arrive through a write port that selects one state word and applies a mask, either as a set or as a clear. Raw interrupt lines arrive as one level vector, which is sampled every clock. An edge-triggered line latches pending on a rising edge of its input. A level-triggered line counts as asserted for as long as its input is high. The eligibility vector is computed for all lines in parallel, from the next-state values. It therefore changes on the same clock edge that captures a write or an input change.

Every line falls into one of three security groups, and each group has its own global enable. When the security-disable control is set, the group modifier is ignored, so secure group 1 folds into group 0.

Top module: `irq_elig_bank`

## Requirements
- R1: Synchronous active-low reset clears every pending, enable, active, trigger, group, modifier and sampled-level bit, and clears the output vector.
- R2: A write with `wr_en`=1 applies `wr_mask` to the word chosen by `wr_sel`. `wr_set`=1 ORs the mask in and `wr_set`=0 clears the masked bits. The select codes are 0 pending, 1 enable, 2 active, 3 trigger mode, 4 group and 5 group modifier.
- R3: A write with select code 6 or 7 changes no state and leaves the output unchanged.
- R4: A line whose trigger bit is 0 (level) is asserted while its input is high, with no pending latch needed.
- R5: A line whose trigger bit is 1 (edge) sets its pending latch on a rising input edge. The latch stays set after the input falls and clears only through a pending-clear write. An edge in the same cycle as a clear of that bit leaves the latch set. A high level alone never asserts an edge line.
- R6: An asserted line is eligible only while its enable bit is 1 and its active bit is 0.
- R7: A line with group bit 1 is non-secure group 1 and passes only while `grp1ns_en` is 1.
- R8: A line with group bit 0 and modifier 1 is secure group 1 and needs `grp1s_en`. A line with group bit 0 and modifier 0 is group 0 and needs `grp0_en`.
- R9: While `sec_dis` is 1, every modifier bit is treated as 0, so all group-bit-0 lines are gated by `grp0_en` alone.
- R10: `elig` changes on the first rising clock edge after a write or an input change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | State write strobe |
| wr_sel | input | 3 | State word select (0 pending … 5 modifier, 6 and 7 unused) |
| wr_set | input | 1 | 1: set masked bits, 0: clear masked bits |
| wr_mask | input | NUM_IRQ | Bit mask of lines affected by the write |
| irq_lvl | input | NUM_IRQ | Raw interrupt input levels |
| grp0_en | input | 1 | Global enable for group 0 |
| grp1s_en | input | 1 | Global enable for secure group 1 |
| grp1ns_en | input | 1 | Global enable for non-secure group 1 |
| sec_dis | input | 1 | Security disable: treat all modifier bits as 0 |
| elig | output | NUM_IRQ | Registered per-line eligibility vector |

## Verification
A table of whole-bank patterns sets every state word at once. The patterns tell apart level assertion against the pending latch, the enable and active masks, and the way a trigger bit suppresses a high level. One fixed group layout splits the bank into non-secure-1, secure-1 and group-0 slices. That layout is run under single group enables, all enables, none, and the security-disable control, so each gate and the modifier collapse show up as a distinct slice of the output. Directed sequences then cover the edge latch: hold after the input falls, clear, edge racing a clear, and no retrigger on a held level. They also cover set-versus-clear writes, writes to unused selects, reset clearing, and the exact edge at which the output moves.

// File: rtl/irq_elig_pkg.sv
package irq_elig_pkg;

    localparam int unsigned SEL_W   = 3;
    localparam int unsigned NUM_CFG = 5;

    typedef enum logic [SEL_W-1:0] {
        SEL_PEND   = 3'd0,
        SEL_ENABLE = 3'd1,
        SEL_ACTIVE = 3'd2,
        SEL_TRIG   = 3'd3,
        SEL_GROUP  = 3'd4,
        SEL_GMOD   = 3'd5
    } reg_sel_e;

    // slot of each configuration word inside the config bank (select code - 1)
    localparam int unsigned CFG_ENABLE = 0;
    localparam int unsigned CFG_ACTIVE = 1;
    localparam int unsigned CFG_TRIG   = 2;
    localparam int unsigned CFG_GROUP  = 3;
    localparam int unsigned CFG_GMOD   = 4;

endpackage

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
    import irq_elig_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [SEL_W-1:0]                    wr_sel,
    input  logic                                wr_set,
    input  logic [NUM_IRQ-1:0]                  wr_mask,
    output logic [NUM_CFG-1:0][NUM_IRQ-1:0]     cfg_d,
    output logic [NUM_CFG-1:0][NUM_IRQ-1:0]     cfg_q
);

    typedef struct packed {
        logic [NUM_CFG-1:0][NUM_IRQ-1:0] word;
    } cfg_state_t;

    cfg_state_t state_d, state_q;
    logic [NUM_CFG-1:0][NUM_IRQ-1:0] word_nxt;

    // one set/clear slice per configuration word; select code is slot + 1
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_word
        logic hit;
        assign hit = wr_en && (wr_sel == SEL_W'(i + 1));
        assign word_nxt[i] = !hit  ? state_q.word[i] :
                             wr_set ? (state_q.word[i] | wr_mask) :
                                      (state_q.word[i] & ~wr_mask);
    end

    always_comb begin
        state_d      = state_q;
        state_d.word = word_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg_d = state_d.word;
    assign cfg_q = state_q.word;

    AST_UNUSED_SEL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel > SEL_GMOD)) |=> $stable(state_q)); // R3

    AST_ENABLE_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_ENABLE) && wr_set) |=>
        ((state_q.word[CFG_ENABLE] & $past(wr_mask)) == $past(wr_mask))); // R2

    AST_ENABLE_CLR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_ENABLE) && !wr_set) |=>
        ((state_q.word[CFG_ENABLE] & $past(wr_mask)) == '0)); // R2

endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track
    import irq_elig_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic               wr_set,
    input  logic [NUM_IRQ-1:0] wr_mask,
    input  logic [NUM_IRQ-1:0] irq_lvl,
    input  logic [NUM_IRQ-1:0] trig_d,
    output logic [NUM_IRQ-1:0] pend_d,
    output logic [NUM_IRQ-1:0] pend_q,
    output logic [NUM_IRQ-1:0] lvl_d
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] pend;
        logic [NUM_IRQ-1:0] lvl;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic [NUM_IRQ-1:0] rise;
    logic [NUM_IRQ-1:0] pend_wr;
    logic               pend_hit;

    always_comb begin
        pend_hit = wr_en && (wr_sel == SEL_PEND);
        rise     = irq_lvl & ~st_q.lvl & trig_d;
        pend_wr  = st_q.pend;
        if (pend_hit) begin
            pend_wr = wr_set ? (st_q.pend | wr_mask) : (st_q.pend & ~wr_mask);
        end
        st_d      = st_q;
        // a captured edge is ORed after the write so a racing clear cannot lose it
        st_d.pend = pend_wr | rise;
        st_d.lvl  = irq_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_d = st_d.pend;
    assign pend_q = st_q.pend;
    assign lvl_d  = st_d.lvl;

    AST_PEND_DROPS_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_sel == SEL_PEND) && !wr_set) |=>
        (($past(st_q.pend) & ~st_q.pend) == '0)); // R5

    AST_LEVEL_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.lvl == $past(irq_lvl))); // R4

endmodule

// File: rtl/irq_elig_gate.sv
module irq_elig_gate #(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [NUM_IRQ-1:0] lvl,
    input  logic [NUM_IRQ-1:0] trig,
    input  logic [NUM_IRQ-1:0] ena,
    input  logic [NUM_IRQ-1:0] act,
    input  logic [NUM_IRQ-1:0] grp,
    input  logic [NUM_IRQ-1:0] gmod,
    input  logic               grp0_en,
    input  logic               grp1s_en,
    input  logic               grp1ns_en,
    input  logic               sec_dis,
    output logic [NUM_IRQ-1:0] elig
);

    logic [NUM_IRQ-1:0] gmod_eff;
    logic [NUM_IRQ-1:0] asserted;
    logic [NUM_IRQ-1:0] open_ns;
    logic [NUM_IRQ-1:0] open_s;
    logic [NUM_IRQ-1:0] open_g0;

    always_comb begin
        gmod_eff = sec_dis ? '0 : gmod;
        asserted = pend | (~trig & lvl);
        open_ns  = grp1ns_en ? grp : '0;
        open_s   = grp1s_en  ? (~grp & gmod_eff)  : '0;
        open_g0  = grp0_en   ? (~grp & ~gmod_eff) : '0;
        elig     = asserted & ena & ~act & (open_ns | open_s | open_g0);
    end

endmodule

// File: rtl/irq_elig_bank.sv
module irq_elig_bank
    import irq_elig_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic               wr_set,
    input  logic [NUM_IRQ-1:0] wr_mask,
    input  logic [NUM_IRQ-1:0] irq_lvl,
    input  logic               grp0_en,
    input  logic               grp1s_en,
    input  logic               grp1ns_en,
    input  logic               sec_dis,
    output logic [NUM_IRQ-1:0] elig
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] elig;
    } out_state_t;

    out_state_t out_d, out_q;

    logic [NUM_CFG-1:0][NUM_IRQ-1:0] cfg_d, cfg_q;
    logic [NUM_IRQ-1:0] pend_d, pend_q, lvl_d;
    logic [NUM_IRQ-1:0] elig_nxt;

    irq_cfg_bank #(.NUM_IRQ(NUM_IRQ)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_set  (wr_set),
        .wr_mask (wr_mask),
        .cfg_d   (cfg_d),
        .cfg_q   (cfg_q)
    );

    irq_pend_track #(.NUM_IRQ(NUM_IRQ)) i_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_set  (wr_set),
        .wr_mask (wr_mask),
        .irq_lvl (irq_lvl),
        .trig_d  (cfg_d[CFG_TRIG]),
        .pend_d  (pend_d),
        .pend_q  (pend_q),
        .lvl_d   (lvl_d)
    );

    irq_elig_gate #(.NUM_IRQ(NUM_IRQ)) i_gate (
        .pend      (pend_d),
        .lvl       (lvl_d),
        .trig      (cfg_d[CFG_TRIG]),
        .ena       (cfg_d[CFG_ENABLE]),
        .act       (cfg_d[CFG_ACTIVE]),
        .grp       (cfg_d[CFG_GROUP]),
        .gmod      (cfg_d[CFG_GMOD]),
        .grp0_en   (grp0_en),
        .grp1s_en  (grp1s_en),
        .grp1ns_en (grp1ns_en),
        .sec_dis   (sec_dis),
        .elig      (elig_nxt)
    );

    always_comb begin
        out_d      = out_q;
        out_d.elig = elig_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign elig = out_q.elig;

    AST_ELIG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.elig & ~cfg_q[CFG_ENABLE]) == '0); // R6

    AST_ELIG_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.elig & cfg_q[CFG_ACTIVE]) == '0); // R6

    AST_EDGE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.elig & cfg_q[CFG_TRIG] & ~pend_q) == '0); // R5

    AST_NO_GROUP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!grp0_en && !grp1s_en && !grp1ns_en) |-> (out_q.elig == '0)); // R7

    AST_NS1_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(grp1ns_en && !grp0_en && !grp1s_en) |->
        ((out_q.elig & ~cfg_q[CFG_GROUP]) == '0)); // R7

    AST_S1_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(grp1s_en && !grp0_en && !grp1ns_en && !sec_dis) |->
        ((out_q.elig & (cfg_q[CFG_GROUP] | ~cfg_q[CFG_GMOD])) == '0)); // R8

    AST_SECDIS_NO_S1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sec_dis && !grp0_en && !grp1ns_en) |-> (out_q.elig == '0)); // R9

endmodule

// File: tb/test_irq_elig_bank.sv
module test_irq_elig_bank;

    localparam int unsigned N = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [2:0]   wr_sel;
    logic         wr_set;
    logic [N-1:0] wr_mask;
    logic [N-1:0] irq_lvl;
    logic         grp0_en, grp1s_en, grp1ns_en, sec_dis;
    logic [N-1:0] elig;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_elig_bank #(.NUM_IRQ(N)) i_irq_elig_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_set    (wr_set),
        .wr_mask   (wr_mask),
        .irq_lvl   (irq_lvl),
        .grp0_en   (grp0_en),
        .grp1s_en  (grp1s_en),
        .grp1ns_en (grp1ns_en),
        .sec_dis   (sec_dis),
        .elig      (elig)
    );

    typedef struct packed {
        logic [31:0] pend;
        logic [31:0] trig;
        logic [31:0] lvl;
        logic [31:0] ena;
        logic [31:0] act;
        logic [31:0] grp;
        logic [31:0] gmod;
        logic [3:0]  ctrl;   // {sec_dis, grp0_en, grp1s_en, grp1ns_en}
        logic [7:0]  req;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        // R4 level lines asserted, R6 enable mask
        '{32'h0, 32'h0, 32'h0000_FFFF, 32'h00FF_00FF, 32'h0, 32'h0, 32'h0, 4'b0100, 8'd4, 32'h0000_00FF},
        // R6 active bits block pending lines
        '{32'hFFFF_0000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0, 32'h0, 4'b0100, 8'd6, 32'hF0F0_0000},
        // R5 edge mode ignores a held high level
        '{32'h0, 32'h0000_FF00, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 4'b0100, 8'd5, 32'h0000_00FF},
        // R7 non-secure group 1 only
        '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF, 32'h00FF_00FF, 4'b0001, 8'd7, 32'h0000_FFFF},
        // R8 secure group 1 only
        '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF, 32'h00FF_00FF, 4'b0010, 8'd8, 32'h00FF_0000},
        // R8 group 0 only
        '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF, 32'h00FF_00FF, 4'b0100, 8'd8, 32'hFF00_0000},
        // R9 security disable folds secure group 1 into group 0
        '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF, 32'h00FF_00FF, 4'b1100, 8'd9, 32'hFFFF_0000},
        // R9 security disable: secure group 1 enable opens nothing
        '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF, 32'h00FF_00FF, 4'b1010, 8'd9, 32'h0000_0000},
        // R7 all groups open
        '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF, 32'h00FF_00FF, 4'b0111, 8'd7, 32'hFFFF_FFFF},
        // R7 no group open
        '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF, 32'h00FF_00FF, 4'b0000, 8'd7, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [N-1:0] expv);
        n_checks++;
        if (elig !== expv) begin
            n_errors++;
            $display("FAIL %s: elig=%h expected=%h", tag, elig, expv);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic st, input logic [N-1:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_set = st; wr_mask = m;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; wr_mask = '0;
    endtask

    task automatic set_ctrl(input logic [3:0] c);
        {sec_dis, grp0_en, grp1s_en, grp1ns_en} = c;
    endtask

    task automatic load(input vec_t v);
        wr(3'd3, 1'b0, '1);          // trigger mode all level first
        set_ctrl(v.ctrl);
        wr(3'd1, 1'b0, '1);
        irq_lvl = v.lvl;
        wr(3'd2, 1'b0, '1);
        wr(3'd4, 1'b0, '1);
        wr(3'd5, 1'b0, '1);
        wr(3'd0, 1'b0, '1);
        wr(3'd1, 1'b1, v.ena);
        wr(3'd2, 1'b1, v.act);
        wr(3'd4, 1'b1, v.grp);
        wr(3'd5, 1'b1, v.gmod);
        wr(3'd0, 1'b1, v.pend);
        wr(3'd3, 1'b1, v.trig);
        idle();
    endtask

    function automatic vec_t blank(input logic [31:0] ena, input logic [3:0] c);
        vec_t v = '0;
        v.ena  = ena;
        v.ctrl = c;
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL R10 watchdog: actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_set = 1'b0; wr_mask = '0;
        irq_lvl = '0; grp0_en = 1'b1; grp1s_en = 1'b1; grp1ns_en = 1'b1; sec_dis = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 output clear in reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 output clear after reset", '0);

        // table walk
        foreach (VECS[i]) begin
            load(VECS[i]);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp);
        end

        // R2 set then clear on the enable word
        load(blank(32'h0, 4'b0100));
        irq_lvl = '1;
        wr(3'd1, 1'b1, 32'h0000_00F0);
        wr(3'd1, 1'b0, 32'h0000_0030);
        idle();
        check("R2 set then clear", 32'h0000_00C0);

        // R3 unused selects change nothing
        load('{32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_00FF,
               32'hFFFF_FFFF, 32'h0, 4'b0001, 8'd3, 32'h0000_FF00});
        check("R3 baseline", 32'h0000_FF00);
        wr(3'd6, 1'b1, '1);
        wr(3'd7, 1'b1, '1);
        wr(3'd7, 1'b0, '1);
        wr(3'd6, 1'b0, '1);
        idle();
        check("R3 after unused selects", 32'h0000_FF00);

        // R5 edge latch behaviour on line 3
        load('{32'h0, 32'h0000_0008, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0,
               4'b0100, 8'd5, 32'h0});
        check("R5 edge line idle", '0);
        irq_lvl = 32'h8;
        @(negedge clk);
        check("R5 rising edge latches", 32'h8);
        irq_lvl = '0;
        @(negedge clk);
        check("R5 latch held after fall", 32'h8);
        wr(3'd0, 1'b0, 32'h8);
        idle();
        check("R5 clear write", '0);
        wr(3'd0, 1'b0, 32'h8);
        irq_lvl = 32'h8;                    // edge in the same cycle as a clear
        idle();
        check("R5 edge beats clear", 32'h8);
        wr(3'd0, 1'b0, 32'h8);              // line held high, no new edge
        idle();
        check("R5 held level no retrigger", '0);
        @(negedge clk);
        check("R5 still clear next cycle", '0);

        // R10 output timing, level line 0
        load(blank(32'hFFFF_FFFF, 4'b0100));
        irq_lvl = 32'h1;
        #1;
        check("R10 no change before edge", '0);
        @(negedge clk);
        check("R10 change after one edge", 32'h1);
        grp0_en = 1'b0;
        #1;
        check("R10 gate change waits for edge", 32'h1);
        @(negedge clk);
        check("R10 gate change after edge", '0);

        // R1 reset wipes pending and enable state
        grp0_en = 1'b1;
        wr(3'd0, 1'b1, 32'h0000_00F0);
        idle();
        check("R1 populated before reset", 32'h0000_00F1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears output", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 enables cleared by reset", '0);
        wr(3'd1, 1'b1, '1);
        idle();
        check("R1 pending cleared by reset", 32'h0000_0001);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule